// File: doc/BRIEF.md
# Ternary Longest-Prefix Match Table

This block is a small ternary lookup table for routing by longest prefix. Each slot holds a 32-bit stored pattern, a 32-bit care mask, a next-hop code and a valid flag. A mask bit of 1 means the key bit must equal the stored bit. A mask bit of 0 means that key bit is ignored. A prefix of length L is loaded with the top L mask bits set and the rest cleared. A length-0 slot therefore matches every key.

Software loads slots through an indexed write port. It keeps them ordered from the longest prefix at slot 0 down to the shortest. On a search strobe, the key is compared with every slot at once. A positional priority encoder then picks the lowest-numbered matching slot. One cycle later, the slot number and its next hop appear on registered outputs, together with a hit flag and a result-valid pulse.

Top module: `tcam_lpm`

## Requirements
- R1: After reset every slot is invalid, and all result outputs (`res_vld`, `res_hit`, `res_idx`, `res_nhop`) are 0.
- R2: A key matches a valid slot when every key bit under a mask bit of 1 equals the stored bit. Key bits under a mask bit of 0 are ignored, and so are stored bits under a mask bit of 0.
- R3: When several valid slots match, the slot with the lowest index wins. Slot 0 has the highest priority.
- R4: A slot written with `wr_valid` = 0 never matches, whatever its pattern and mask.
- R5: `res_vld` is high for exactly the one cycle after each cycle in which `srch_en` is high, and low otherwise. Back-to-back strobes give back-to-back results.
- R6: With no matching slot, `res_hit` is 0 and `res_idx` and `res_nhop` are 0. On a hit, `res_hit` is 1 and `res_nhop` is the next hop of the winning slot.
- R7: A write in the same cycle as a search does not affect that search; it is seen by later searches only.
- R8: A slot with an all-zero mask (prefix length 0) matches every key.
- R9: Every slot from 0 to DEPTH-1 can be written and can win, including the last slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for one slot |
| wr_idx | input | IDX_W | Slot number to write |
| wr_valid | input | 1 | Valid flag stored with the slot |
| wr_value | input | KEY_W | Stored pattern |
| wr_mask | input | KEY_W | Care mask, 1 = compare, 0 = ignore |
| wr_nhop | input | NH_W | Next hop stored with the slot |
| srch_en | input | 1 | Search strobe |
| srch_key | input | KEY_W | Search key |
| res_vld | output | 1 | Result valid, one cycle after the strobe |
| res_hit | output | 1 | Some valid slot matched |
| res_idx | output | IDX_W | Winning slot number, 0 on a miss |
| res_nhop | output | NH_W | Winning next hop, 0 on a miss |

## Verification
A slot write and a search can fall in the same clock cycle. The compare must then use the slot's contents from before the write. The bench provokes this by invalidating the catch-all slot, then driving a write that revalidates it in the same cycle as a search whose key only that slot can match. The first result must be a miss. An identical search on the next cycle must then hit that slot. This judges that the write took effect only for later searches.

// File: rtl/tcam_pkg.sv
package tcam_pkg;

  // Default geometry of the table
  localparam int unsigned TCAM_DEPTH_DEF = 16;
  localparam int unsigned TCAM_KEY_W_DEF = 32;
  localparam int unsigned TCAM_NH_W_DEF  = 8;

  // Index width for a table of a given depth (at least one bit)
  function automatic int unsigned idx_width(input int unsigned depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = TCAM_DEPTH_DEF,
  parameter int unsigned KEY_W = TCAM_KEY_W_DEF,
  parameter int unsigned NH_W  = TCAM_NH_W_DEF,
  parameter int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [NH_W-1:0]  wr_nhop,
  output logic [DEPTH-1:0] ent_valid,
  output logic [KEY_W-1:0] ent_value [DEPTH],
  output logic [KEY_W-1:0] ent_mask  [DEPTH],
  output logic [NH_W-1:0]  ent_nhop  [DEPTH]
);

  // Decoded one-hot write select
  logic [DEPTH-1:0] sel;

  always_comb begin
    sel = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (wr_en && (wr_idx == IDX_W'(i))) begin
        sel[i] = 1'b1;
      end
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    // Valid flag: the only state cleared by reset
    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
      end else if (sel[g]) begin
        ent_valid[g] <= wr_valid;
      end
    end

    // Payload: no reset; ignored bits are cleared on write
    always_ff @(posedge clk) begin
      if (sel[g]) begin
        ent_value[g] <= wr_value & wr_mask;
        ent_mask[g]  <= wr_mask;
        ent_nhop[g]  <= wr_nhop;
      end
    end
  end

endmodule

// File: rtl/tcam_match_array.sv
module tcam_match_array
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = TCAM_DEPTH_DEF,
  parameter int unsigned KEY_W = TCAM_KEY_W_DEF
) (
  input  logic [KEY_W-1:0] key,
  input  logic [DEPTH-1:0] ent_valid,
  input  logic [KEY_W-1:0] ent_value [DEPTH],
  input  logic [KEY_W-1:0] ent_mask  [DEPTH],
  output logic [DEPTH-1:0] match
);

  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic [KEY_W-1:0] diff;
    assign diff     = (key ^ ent_value[g]) & ent_mask[g];
    assign match[g] = ent_valid[g] && (diff == '0);
  end

endmodule

// File: rtl/tcam_prio_enc.sv
module tcam_prio_enc
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = TCAM_DEPTH_DEF,
  parameter int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic [DEPTH-1:0] req,
  output logic             any,
  output logic [IDX_W-1:0] idx
);

  // Lowest set position wins: scan downward so the last write is the lowest
  always_comb begin
    idx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
      end
    end
  end

  assign any = |req;

endmodule

// File: rtl/tcam_lpm.sv
module tcam_lpm
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = TCAM_DEPTH_DEF,
  parameter int unsigned KEY_W = TCAM_KEY_W_DEF,
  parameter int unsigned NH_W  = TCAM_NH_W_DEF,
  parameter int unsigned IDX_W = idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_valid,
  input  logic [KEY_W-1:0] wr_value,
  input  logic [KEY_W-1:0] wr_mask,
  input  logic [NH_W-1:0]  wr_nhop,
  input  logic             srch_en,
  input  logic [KEY_W-1:0] srch_key,
  output logic             res_vld,
  output logic             res_hit,
  output logic [IDX_W-1:0] res_idx,
  output logic [NH_W-1:0]  res_nhop
);

  logic [DEPTH-1:0] ent_valid;
  logic [KEY_W-1:0] ent_value [DEPTH];
  logic [KEY_W-1:0] ent_mask  [DEPTH];
  logic [NH_W-1:0]  ent_nhop  [DEPTH];
  logic [DEPTH-1:0] match;
  logic             win_any;
  logic [IDX_W-1:0] win_idx;
  logic [NH_W-1:0]  win_nhop;

  tcam_entry_store #(
    .DEPTH(DEPTH), .KEY_W(KEY_W), .NH_W(NH_W), .IDX_W(IDX_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_valid (wr_valid),
    .wr_value (wr_value),
    .wr_mask  (wr_mask),
    .wr_nhop  (wr_nhop),
    .ent_valid(ent_valid),
    .ent_value(ent_value),
    .ent_mask (ent_mask),
    .ent_nhop (ent_nhop)
  );

  tcam_match_array #(
    .DEPTH(DEPTH), .KEY_W(KEY_W)
  ) u_match (
    .key      (srch_key),
    .ent_valid(ent_valid),
    .ent_value(ent_value),
    .ent_mask (ent_mask),
    .match    (match)
  );

  tcam_prio_enc #(
    .DEPTH(DEPTH), .IDX_W(IDX_W)
  ) u_prio (
    .req(match),
    .any(win_any),
    .idx(win_idx)
  );

  assign win_nhop = ent_nhop[win_idx];

  // Registered result; zeroed fields on a miss
  always_ff @(posedge clk) begin
    if (rst) begin
      res_vld  <= 1'b0;
      res_hit  <= 1'b0;
      res_idx  <= '0;
      res_nhop <= '0;
    end else begin
      res_vld <= srch_en;
      if (srch_en) begin
        res_hit  <= win_any;
        res_idx  <= win_any ? win_idx  : '0;
        res_nhop <= win_any ? win_nhop : '0;
      end
    end
  end

endmodule

// File: rtl/tcam_lpm_chk.sv
module tcam_lpm_chk
  import tcam_pkg::*;
#(
  parameter int unsigned DEPTH = TCAM_DEPTH_DEF,
  parameter int unsigned KEY_W = TCAM_KEY_W_DEF,
  parameter int unsigned NH_W  = TCAM_NH_W_DEF,
  parameter int unsigned IDX_W = idx_width(DEPTH)
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_idx,
  input logic             wr_valid,
  input logic             srch_en,
  input logic             res_vld,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_idx,
  input logic [NH_W-1:0]  res_nhop
);

  // Shadow of slot validity, rebuilt from the write port alone
  logic [DEPTH-1:0] shadow_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_vld <= '0;
    end else if (wr_en && (int'(wr_idx) < DEPTH)) begin
      shadow_vld[wr_idx] <= wr_valid;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    $past(rst) |-> (!res_vld && !res_hit && res_idx == '0 && res_nhop == '0));

  // R5
  strobe_result_chk: assert property (@(posedge clk) disable iff (rst)
    srch_en |=> res_vld);

  // R5
  no_strobe_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !srch_en |=> !res_vld);

  // R6
  miss_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (res_vld && !res_hit) |-> (res_idx == '0 && res_nhop == '0));

  // R4
  empty_no_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (srch_en && shadow_vld == '0) |=> !res_hit);

endmodule

bind tcam_lpm tcam_lpm_chk #(
  .DEPTH(DEPTH), .KEY_W(KEY_W), .NH_W(NH_W), .IDX_W(IDX_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .wr_idx  (wr_idx),
  .wr_valid(wr_valid),
  .srch_en (srch_en),
  .res_vld (res_vld),
  .res_hit (res_hit),
  .res_idx (res_idx),
  .res_nhop(res_nhop)
);

// File: tb/tb_tcam_lpm.sv
`timescale 1ns/1ps
module tb_tcam_lpm;

  localparam int DEPTH = 16;
  localparam int KEY_W = 32;
  localparam int NH_W  = 8;
  localparam int IDX_W = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic [IDX_W-1:0] wr_idx = '0;
  logic             wr_valid = 1'b0;
  logic [KEY_W-1:0] wr_value = '0;
  logic [KEY_W-1:0] wr_mask = '0;
  logic [NH_W-1:0]  wr_nhop = '0;
  logic             srch_en = 1'b0;
  logic [KEY_W-1:0] srch_key = '0;
  logic             res_vld;
  logic             res_hit;
  logic [IDX_W-1:0] res_idx;
  logic [NH_W-1:0]  res_nhop;

  always #2.5 clk = ~clk;

  tcam_lpm #(.DEPTH(DEPTH), .KEY_W(KEY_W), .NH_W(NH_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_valid(wr_valid),
    .wr_value(wr_value), .wr_mask(wr_mask), .wr_nhop(wr_nhop),
    .srch_en(srch_en), .srch_key(srch_key),
    .res_vld(res_vld), .res_hit(res_hit), .res_idx(res_idx), .res_nhop(res_nhop)
  );

  typedef struct {
    logic             hit;
    logic [IDX_W-1:0] idx;
    logic [NH_W-1:0]  nh;
    string            tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  // Bench model of the table, built from the requirements
  logic [KEY_W-1:0] m_val [DEPTH];
  logic [KEY_W-1:0] m_msk [DEPTH];
  logic [NH_W-1:0]  m_nh  [DEPTH];
  logic             m_vld [DEPTH];

  function automatic logic [KEY_W-1:0] pmask(input int len);
    if (len == 0) return '0;
    return ~32'h0 << (KEY_W - len);
  endfunction

  function automatic exp_t predict(input logic [KEY_W-1:0] key, input string tag);
    exp_t e;
    e.hit = 1'b0; e.idx = '0; e.nh = '0; e.tag = tag;
    for (int i = 0; i < DEPTH; i++) begin
      if (!e.hit && m_vld[i] && (((key ^ m_val[i]) & m_msk[i]) == '0)) begin
        e.hit = 1'b1; e.idx = IDX_W'(i); e.nh = m_nh[i];
      end
    end
    return e;
  endfunction

  // Drives at a negedge, returns at the next negedge
  task automatic do_write(input int idx, input logic vld, input logic [KEY_W-1:0] val,
                          input int len, input logic [NH_W-1:0] nh);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = vld;
    wr_value = val; wr_mask = pmask(len); wr_nhop = nh;
    @(negedge clk);
    m_vld[idx] = vld; m_val[idx] = val; m_msk[idx] = pmask(len); m_nh[idx] = nh;
    wr_en = 1'b0;
  endtask

  task automatic do_write_mask(input int idx, input logic [KEY_W-1:0] val,
                               input logic [KEY_W-1:0] msk, input logic [NH_W-1:0] nh);
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = 1'b1;
    wr_value = val; wr_mask = msk; wr_nhop = nh;
    @(negedge clk);
    m_vld[idx] = 1'b1; m_val[idx] = val; m_msk[idx] = msk; m_nh[idx] = nh;
    wr_en = 1'b0;
  endtask

  task automatic do_search(input logic [KEY_W-1:0] key, input string tag);
    srch_en = 1'b1; srch_key = key;
    exp_q.push_back(predict(key, tag));
    @(negedge clk);
    srch_en = 1'b0;
  endtask

  // Write and search in the same cycle: prediction uses the old table
  task automatic do_write_search(input int idx, input logic [KEY_W-1:0] val, input int len,
                                 input logic [NH_W-1:0] nh, input logic [KEY_W-1:0] key,
                                 input string tag);
    srch_en = 1'b1; srch_key = key;
    exp_q.push_back(predict(key, tag));
    wr_en = 1'b1; wr_idx = IDX_W'(idx); wr_valid = 1'b1;
    wr_value = val; wr_mask = pmask(len); wr_nhop = nh;
    @(negedge clk);
    m_vld[idx] = 1'b1; m_val[idx] = val; m_msk[idx] = pmask(len); m_nh[idx] = nh;
    wr_en = 1'b0; srch_en = 1'b0;
  endtask

  // Monitor: compare each result against the oldest expectation
  always @(negedge clk) begin
    if (!rst && res_vld) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5: res_vld high with no search pending (actual 1, expected 0)");
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (res_hit !== e.hit || res_idx !== e.idx || res_nhop !== e.nh) begin
          n_bad++;
          $display("FAIL %s: actual hit=%0b idx=%0d nh=%02h, expected hit=%0b idx=%0d nh=%02h",
                   e.tag, res_hit, res_idx, res_nhop, e.hit, e.idx, e.nh);
        end
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end (actual timeout, expected completion)");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      m_vld[i] = 1'b0; m_val[i] = '0; m_msk[i] = '0; m_nh[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1: outputs cleared by reset
    n_cmp++;
    if (res_vld !== 1'b0 || res_hit !== 1'b0 || res_idx !== '0 || res_nhop !== '0) begin
      n_bad++;
      $display("FAIL R1: actual vld=%0b hit=%0b idx=%0d nh=%02h, expected all 0",
               res_vld, res_hit, res_idx, res_nhop);
    end
    // R1: empty table misses; R6 zero fields
    do_search(32'hC0A8_0001, "R1");

    // Longest prefixes at low slots
    do_write(2,  1'b1, 32'h0A0B_0C77, 24, 8'h22);   // R2: bits under mask 0 ignored
    do_write(7,  1'b1, 32'h0A0B_0000, 16, 8'h77);
    do_write(10, 1'b1, 32'h0A00_0000, 8,  8'hAA);
    do_write(15, 1'b1, 32'hDEAD_BEEF, 0,  8'hFF);   // R8 default route in last slot (R9)
    do_write_mask(0, 32'h1122_0033, 32'hFFFF_00FF, 8'h01);

    // R3: several matches, lowest slot wins; back-to-back strobes (R5)
    do_search(32'h0A0B_0C01, "R3");
    do_search(32'h0A0B_FF01, "R3");
    do_search(32'h0AFF_0001, "R3");
    // R8 / R9: only the length-0 slot 15 matches
    do_search(32'hC0A8_0001, "R8");
    // R2: middle don't-care byte, both values
    do_search(32'h1122_AB33, "R2");
    do_search(32'h1122_0033, "R2");
    do_search(32'h1123_AB33, "R2");
    @(negedge clk);
    @(negedge clk);

    // R4: invalidated slot no longer matches; R6 miss fields zero
    do_write(15, 1'b0, 32'h0000_0000, 0, 8'hFF);
    do_search(32'hC0A8_0001, "R4");
    do_write(2, 1'b0, 32'h0A0B_0C00, 24, 8'h22);
    do_search(32'h0A0B_0C01, "R4");

    // R7: same-cycle write is not seen by the concurrent search
    do_write_search(15, 32'h0, 0, 8'h99, 32'hC0A8_0001, "R7");
    do_search(32'hC0A8_0001, "R7");

    // R9: slot 0 with full-length prefix
    do_write(0, 1'b1, 32'hFFFF_FFFF, 32, 8'h5A);
    do_search(32'hFFFF_FFFF, "R9");
    do_search(32'hFFFF_FFFE, "R9");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL R5: %0d results missing (actual 0, expected %0d)", exp_q.size(), exp_q.size());
    end
    finish_run();
  end

endmodule